// File: doc/BRIEF.md
# Indexed Codec Register Interface

This block is the host-facing control front end of an audio codec. A host reaches it through four byte-wide ports picked by a 2-bit offset. One port holds a pointer into a bank of 32 internal 8-bit registers. A second port reads or writes the register that the pointer selects. A third port reports and acknowledges the playback interrupt. The fourth is a programmed-I/O data port, which this block accepts but does not act on. The pointer is 4 bits wide in the basic mode and 5 bits wide in the extended mode. Bit 6 of internal register 12 selects the mode.

Writes to the internal registers are filtered. Some registers are reserved or read-only and keep their value. The playback format register (8) changes only while mode-change-enable (pointer bit 6) is set, or, in a restricted way, while the playback-mode-change flag (bit 4 of register 24) is set. After a mode-change-enable rising edge, a short calibration window makes reads of register 11 show a "calibrating" flag.

The block sends the playback engine the playback enable, the format byte, the extended-mode bit and the interrupt-enable bit. It also sends a one-cycle strobe after every write to the interface configuration register. The engine reports the end of a block through a single-cycle request input. That request raises the interrupt.

Top module: `codec_index_regs`

## Requirements
- R1: Port offset 0 holds the index pointer. It resets to 0x40, bit 7 is never stored, and reading offset 0 returns the stored value with bit 7 equal to 0.
- R2: The data port (offset 1) addresses internal register (pointer & 0x0F) while bit 6 of register 12 is 0, and (pointer & 0x1F) while that bit is 1.
- R3: Writes to internal registers 11, 22, 27 and 29 leave them unchanged.
- R4: A 0-to-1 change of pointer bit 6, made while bits 4:3 of register 9 are not both zero, loads a calibration counter with CAL_INIT (default 1). While the counter is nonzero, each data-port read of register 11 returns bit 5 set and decrements the counter. If bits 4:3 of register 9 are both zero, there is no load.
- R5: A write to register 8 is stored whole when pointer bit 6 is set. Otherwise it is stored only if bit 4 of register 24 is set, and then bits 3:0 keep their old value. In all other cases it is dropped. `play_fmt` shows register 8.
- R6: A write to register 9 stores the value with bit 5 forced to 0, and `cfg_strobe` is high for exactly the one following cycle. Writes to other registers give no strobe. `play_en` is register 9 bit 0 and `irq_en` is register 10 bit 1.
- R7: In register 12 only bit 6 is writable, and `mode_ext` shows that bit.
- R8: Any write to the status port (offset 2) clears status bit 0 and bits 6:4 of register 24. `irq_o` is low from the next cycle.
- R9: Writing register 24 with bit 4 = 0 while its bit 4 was 1 clears status bit 0 and drops `irq_o`. Writing with bit 4 = 1 leaves the interrupt alone.
- R10: The reset values are 0x88 for registers 2–5 and 18–19, 0x80 for registers 6–7, 0x08 for register 9, 0x8A for register 12, 0xA0 for registers 25–26, and 0x00 for all others. The status byte resets to 0x00.
- R11: A one-cycle `pb_done` pulse sets status bit 0 (read at offset 2) and register 24 bit 4, and raises `irq_o`.
- R12: Writes to the programmed-I/O port (offset 3) have no effect, and reads of it return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_rd | input | 1 | Host read strobe, one cycle per byte |
| bus_addr | input | 2 | Port offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data of the addressed port (combinational) |
| pb_done | input | 1 | Playback block-end request from the engine |
| irq_o | output | 1 | Interrupt to the host |
| play_en | output | 1 | Playback enable |
| play_fmt | output | 8 | Playback format byte |
| mode_ext | output | 1 | Extended register mode |
| irq_en | output | 1 | Interrupt enable for the engine |
| cfg_strobe | output | 1 | One-cycle pulse after a configuration write |

## Verification
The assertions assume that the host never raises `bus_wr` and `bus_rd` in the same cycle. They also assume that a `pb_done` request does not coincide with a status-port acknowledge, because otherwise the request wins and the acknowledge checks do not apply. The stimulus moves one port access at a time, each lasting one cycle. It pulses `pb_done` only between accesses, so both assumptions hold throughout the run.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_IREG = 32;
    localparam int IREG_W   = $clog2(NUM_IREG);
    localparam int PTR_W    = 7;

    typedef logic [DATA_W-1:0]                byte_t;
    typedef logic [IREG_W-1:0]                ireg_idx_t;
    typedef logic [NUM_IREG-1:0][DATA_W-1:0]  ireg_bank_t;

    typedef enum logic [1:0] {
        PORT_INDEX  = 2'd0,
        PORT_DATA   = 2'd1,
        PORT_STATUS = 2'd2,
        PORT_PIO    = 2'd3
    } port_e;

    localparam ireg_idx_t IX_FORMAT  = 5'd8;
    localparam ireg_idx_t IX_IFCFG   = 5'd9;
    localparam ireg_idx_t IX_PINS    = 5'd10;
    localparam ireg_idx_t IX_CALSTAT = 5'd11;
    localparam ireg_idx_t IX_MODE    = 5'd12;
    localparam ireg_idx_t IX_RSV_A   = 5'd22;
    localparam ireg_idx_t IX_FLAGS   = 5'd24;
    localparam ireg_idx_t IX_RSV_B   = 5'd27;
    localparam ireg_idx_t IX_RSV_C   = 5'd29;

    localparam int BIT_MCE    = 6;
    localparam int BIT_EXT    = 6;
    localparam int BIT_PBFLAG = 4;
    localparam int BIT_CALRD  = 5;

    function automatic byte_t ireg_default(input int idx);
        byte_t v;
        case (idx)
            2, 3, 4, 5, 18, 19: v = 8'h88;
            6, 7:               v = 8'h80;
            9:                  v = 8'h08;
            12:                 v = 8'h8A;
            25, 26:             v = 8'hA0;
            default:            v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic ireg_bank_t ireg_defaults();
        ireg_bank_t b;
        for (int i = 0; i < NUM_IREG; i++) begin
            b[i] = ireg_default(i);
        end
        return b;
    endfunction

endpackage

// File: rtl/codec_port_decode.sv
module codec_port_decode
    import codec_reg_pkg::*;
(
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [1:0]           bus_addr,
    input  logic [PTR_W-1:0]     ptr_q,
    input  logic                 ext_mode,
    output logic [3:0]           wr_sel,
    output logic [3:0]           rd_sel,
    output ireg_idx_t            ind_idx
);
    localparam int NPORTS = 4;

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        assign wr_sel[g] = bus_wr && (bus_addr == 2'(g));
        assign rd_sel[g] = bus_rd && (bus_addr == 2'(g));
    end

    always_comb begin
        if (ext_mode) begin
            ind_idx = ptr_q[IREG_W-1:0];
        end else begin
            ind_idx = {1'b0, ptr_q[IREG_W-2:0]};
        end
    end

endmodule

// File: rtl/codec_calib_ctr.sv
module codec_calib_ctr #(
    parameter int CNT_W    = 4,
    parameter int CAL_INIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic busy
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cal_state_t;

    cal_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cnt = CNT_W'(CAL_INIT);
        end else if (dec && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.cnt != '0);

    AST_CAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (s_q.cnt == CNT_W'(CAL_INIT))) else $error("cal load"); // R4
    AST_CAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && busy) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1)) else $error("cal step"); // R4

endmodule

// File: rtl/codec_index_regs.sv
module codec_index_regs
    import codec_reg_pkg::*;
#(
    parameter int CAL_CNT_W = 4,
    parameter int CAL_INIT  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pb_done,
    output logic       irq_o,
    output logic       play_en,
    output logic [7:0] play_fmt,
    output logic       mode_ext,
    output logic       irq_en,
    output logic       cfg_strobe
);
    localparam ireg_bank_t BANK_RST = ireg_defaults();
    localparam logic [PTR_W-1:0] PTR_RST = 7'h40;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        ireg_bank_t       bank;
        logic             pend;
        logic             strobe;
    } regs_t;

    regs_t r_d, r_q;

    logic [3:0] wr_sel, rd_sel;
    ireg_idx_t  ind_idx;
    logic       cal_load, cal_dec, cal_busy;
    logic       data_wr;

    codec_port_decode u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .ptr_q    (r_q.ptr),
        .ext_mode (r_q.bank[IX_MODE][BIT_EXT]),
        .wr_sel   (wr_sel),
        .rd_sel   (rd_sel),
        .ind_idx  (ind_idx)
    );

    codec_calib_ctr #(
        .CNT_W    (CAL_CNT_W),
        .CAL_INIT (CAL_INIT)
    ) u_cal (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cal_load),
        .dec   (cal_dec),
        .busy  (cal_busy)
    );

    assign data_wr  = wr_sel[PORT_DATA];
    assign cal_load = wr_sel[PORT_INDEX] && !r_q.ptr[BIT_MCE] && bus_wdata[BIT_MCE]
                      && (r_q.bank[IX_IFCFG][4:3] != 2'b00);
    assign cal_dec  = rd_sel[PORT_DATA] && (ind_idx == IX_CALSTAT);

    always_comb begin
        r_d        = r_q;
        r_d.strobe = 1'b0;

        if (wr_sel[PORT_INDEX]) begin
            r_d.ptr = bus_wdata[PTR_W-1:0];
        end

        if (data_wr) begin
            case (ind_idx)
                IX_RSV_A, IX_RSV_B, IX_RSV_C, IX_CALSTAT: begin
                    r_d.bank = r_q.bank;
                end
                IX_FORMAT: begin
                    if (r_q.ptr[BIT_MCE]) begin
                        r_d.bank[IX_FORMAT] = bus_wdata;
                    end else if (r_q.bank[IX_FLAGS][BIT_PBFLAG]) begin
                        r_d.bank[IX_FORMAT] = {bus_wdata[7:4], r_q.bank[IX_FORMAT][3:0]};
                    end
                end
                IX_IFCFG: begin
                    r_d.bank[IX_IFCFG] = bus_wdata & 8'hDF;
                    r_d.strobe         = 1'b1;
                end
                IX_MODE: begin
                    r_d.bank[IX_MODE][BIT_EXT] = bus_wdata[BIT_EXT];
                end
                IX_FLAGS: begin
                    r_d.bank[IX_FLAGS] = bus_wdata;
                    if (r_q.bank[IX_FLAGS][BIT_PBFLAG] && !bus_wdata[BIT_PBFLAG]) begin
                        r_d.pend = 1'b0;
                    end
                end
                default: begin
                    r_d.bank[ind_idx] = bus_wdata;
                end
            endcase
        end

        if (wr_sel[PORT_STATUS]) begin
            r_d.pend                = 1'b0;
            r_d.bank[IX_FLAGS][6:4] = 3'b000;
        end

        if (pb_done) begin
            r_d.pend                       = 1'b1;
            r_d.bank[IX_FLAGS][BIT_PBFLAG] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{ptr: PTR_RST, bank: BANK_RST, pend: 1'b0, strobe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (port_e'(bus_addr))
            PORT_INDEX:  bus_rdata = {1'b0, r_q.ptr};
            PORT_DATA: begin
                bus_rdata = r_q.bank[ind_idx];
                if ((ind_idx == IX_CALSTAT) && cal_busy) begin
                    bus_rdata[BIT_CALRD] = 1'b1;
                end
            end
            PORT_STATUS: bus_rdata = {7'b0, r_q.pend};
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign irq_o      = r_q.pend;
    assign play_en    = r_q.bank[IX_IFCFG][0];
    assign play_fmt   = r_q.bank[IX_FORMAT];
    assign mode_ext   = r_q.bank[IX_MODE][BIT_EXT];
    assign irq_en     = r_q.bank[IX_PINS][1];
    assign cfg_strobe = r_q.strobe;

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)) else $error("rd and wr together"); // R1
    AST_PTR_MSB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel[PORT_INDEX] |-> !bus_rdata[7]) else $error("pointer msb"); // R1
    AST_CALSTAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && ind_idx == IX_CALSTAT) |=> $stable(r_q.bank[IX_CALSTAT])) else $error("reg11 written"); // R3
    AST_FMT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && ind_idx == IX_FORMAT && !r_q.ptr[BIT_MCE] && !r_q.bank[IX_FLAGS][BIT_PBFLAG])
        |=> $stable(play_fmt)) else $error("format changed while locked"); // R5
    AST_FMT_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && ind_idx == IX_FORMAT && !r_q.ptr[BIT_MCE])
        |=> (play_fmt[3:0] == $past(play_fmt[3:0]))) else $error("format nibble"); // R5
    AST_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_strobe |-> $past(data_wr && ind_idx == IX_IFCFG)) else $error("stray strobe"); // R6
    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[PORT_STATUS] && !pb_done) |=> !irq_o) else $error("irq after ack"); // R8
    AST_REQ_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        pb_done |=> irq_o) else $error("irq not raised"); // R11

endmodule

// File: tb/codec_index_regs_tb.sv
module codec_index_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pb_done = 1'b0;
    logic       irq_o, play_en, mode_ext, irq_en, cfg_strobe;
    logic [7:0] play_fmt;

    int total = 0;
    int bad = 0;
    int n_strobe = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    codec_index_regs u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pb_done    (pb_done),
        .irq_o      (irq_o),
        .play_en    (play_en),
        .play_fmt   (play_fmt),
        .mode_ext   (mode_ext),
        .irq_en     (irq_en),
        .cfg_strobe (cfg_strobe)
    );

    always @(posedge clk) if (rst_n && cfg_strobe) n_strobe++;

    // {op, port, data, expect}; op 0 = write, 1 = read and compare
    localparam int NVEC = 44;
    localparam logic [19:0] VEC [NVEC] = '{
        {2'd1, 2'd0, 8'h00, 8'h40},  // R1 pointer reset
        {2'd0, 2'd0, 8'h02, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h88},  // R10
        {2'd0, 2'd0, 8'h07, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h80},  // R10
        {2'd0, 2'd0, 8'h09, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h08},  // R10
        {2'd0, 2'd0, 8'h0C, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h8A},  // R10
        {2'd0, 2'd0, 8'h0B, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h00},  // R10
        {2'd0, 2'd0, 8'h16, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h80},  // R2 4-bit index -> reg 6
        {2'd0, 2'd0, 8'h0C, 8'h00},
        {2'd0, 2'd1, 8'hFF, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'hCA},  // R7 only bit 6 taken
        {2'd0, 2'd0, 8'h16, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h00},  // R2 5-bit index -> reg 22
        {2'd0, 2'd1, 8'h55, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h00},  // R3 reg 22
        {2'd0, 2'd0, 8'h19, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'hA0},  // R10
        {2'd0, 2'd0, 8'h1A, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'hA0},  // R10
        {2'd0, 2'd0, 8'h13, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h88},  // R10
        {2'd0, 2'd0, 8'h1B, 8'h00},
        {2'd0, 2'd1, 8'h33, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h00},  // R3 reg 27
        {2'd0, 2'd0, 8'h1D, 8'h00},
        {2'd0, 2'd1, 8'h44, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h00},  // R3 reg 29
        {2'd0, 2'd0, 8'h0B, 8'h00},
        {2'd0, 2'd1, 8'h77, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'h00},  // R3 reg 11
        {2'd0, 2'd0, 8'h09, 8'h00},
        {2'd0, 2'd1, 8'hFF, 8'h00},
        {2'd1, 2'd1, 8'h00, 8'hDF},  // R6 bit 5 dropped
        {2'd0, 2'd0, 8'hFF, 8'h00},
        {2'd1, 2'd0, 8'h00, 8'h7F},  // R1 msb not stored
        {2'd1, 2'd1, 8'h00, 8'h00},  // R10 reg 31
        {2'd0, 2'd3, 8'hAA, 8'h00},
        {2'd1, 2'd3, 8'h00, 8'h00},  // R12
        {2'd1, 2'd2, 8'h00, 8'h00}   // R10 status
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] port, input logic [7:0] d);
        @(negedge clk);
        bus_addr = port; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] port, output logic [7:0] v);
        @(negedge clk);
        bus_addr = port; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        pb_done = 1'b1;
        @(negedge clk);
        pb_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state of outputs
        check("R10 irq", {7'b0, irq_o}, 8'h00);
        check("R10 play_en", {7'b0, play_en}, 8'h00);
        check("R10 play_fmt", play_fmt, 8'h00);
        check("R10 mode_ext", {7'b0, mode_ext}, 8'h00);
        check("R10 irq_en", {7'b0, irq_en}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19:18] == 2'd0) begin
                wr(VEC[i][17:16], VEC[i][15:8]);
            end else begin
                rd(VEC[i][17:16], v);
                check($sformatf("table[%0d]", i), v, VEC[i][7:0]);
            end
        end
        check("R7 mode_ext", {7'b0, mode_ext}, 8'h01);

        // R4 calibration flag after mode-change-enable rise
        wr(2'd0, 8'h0B);
        wr(2'd0, 8'h4B);
        rd(2'd1, v); check("R4 first read", v, 8'h20);
        rd(2'd1, v); check("R4 second read", v, 8'h00);
        wr(2'd0, 8'h09);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h0B);
        wr(2'd0, 8'h4B);
        rd(2'd1, v); check("R4 no load when 4:3 zero", v, 8'h00);

        // R5 format register gating
        wr(2'd0, 8'h08);
        wr(2'd1, 8'h12);
        rd(2'd1, v); check("R5 dropped", v, 8'h00);
        wr(2'd0, 8'h48);
        wr(2'd1, 8'h5A);
        rd(2'd1, v); check("R5 mce write", v, 8'h5A);
        check("R5 play_fmt", play_fmt, 8'h5A);
        wr(2'd0, 8'h18);
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h08);
        wr(2'd1, 8'hA3);
        rd(2'd1, v); check("R5 nibble kept", v, 8'hAA);

        // R11 and R9
        pulse_done();
        check("R11 irq raised", {7'b0, irq_o}, 8'h01);
        rd(2'd2, v); check("R11 status", v, 8'h01);
        wr(2'd0, 8'h18);
        wr(2'd1, 8'h00);
        check("R9 irq cleared", {7'b0, irq_o}, 8'h00);
        rd(2'd2, v); check("R9 status", v, 8'h00);

        // R8 status port acknowledge
        pulse_done();
        wr(2'd1, 8'h70);
        check("R9 bit4 kept no clear", {7'b0, irq_o}, 8'h01);
        wr(2'd2, 8'h00);
        check("R8 irq dropped", {7'b0, irq_o}, 8'h00);
        rd(2'd1, v); check("R8 flags cleared", v, 8'h00);

        // R6 strobe and exported controls
        s0 = n_strobe;
        wr(2'd0, 8'h09);
        wr(2'd1, 8'h21);
        repeat (3) @(negedge clk);
        check("R6 one strobe", 8'(n_strobe - s0), 8'h01);
        check("R6 play_en", {7'b0, play_en}, 8'h01);
        rd(2'd1, v); check("R6 reg9", v, 8'h01);
        s0 = n_strobe;
        wr(2'd0, 8'h0A);
        wr(2'd1, 8'h02);
        repeat (2) @(negedge clk);
        check("R6 irq_en", {7'b0, irq_en}, 8'h01);
        check("R6 no strobe reg10", 8'(n_strobe - s0), 8'h00);

        // R7 clear extended mode
        wr(2'd0, 8'h0C);
        wr(2'd1, 8'h00);
        check("R7 mode_ext off", {7'b0, mode_ext}, 8'h00);
        rd(2'd1, v); check("R7 reg12", v, 8'h8A);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule